// File: doc/BRIEF.md
# In-Order Commit Store Queue

This block is a circular queue of pending stores between the execution pipeline and a private data cache. Slots are claimed in program order. A store fills in its byte address and data when it executes. The retirement stage then marks stores as retired, oldest first. Retired stores drain into the cache strictly from the head, and only while the cache reports that the head's line is held with write permission (Exclusive or Modified). When the two oldest stores are both retired and fall in the same 64-byte line, they leave together in one cycle on two commit lanes.

A speculation flush discards every store that has not yet retired. Retired stores are kept and still drain. To overlap ownership misses, the queue raises read-for-ownership prefetch requests for any executed entry, not only the head. It issues one request at a time, always for the oldest entry that has not yet sent one.

Loads from the same core probe the queue and receive the data of the youngest buffered store with an exact address match. A fence watches the drained flag and holds later loads until the queue is empty.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty: `drained` is 1, `alloc_ready` is 1, `alloc_tag` is 0, and both `cmt_valid` and `pf_valid` are 0.
- R2: Allocation hands out slot tags in ascending order modulo DEPTH, with one slot per accepted request. With DEPTH entries held, `alloc_ready` is 0 and a request is ignored.
- R3: A store that has not retired never appears on the commit port, even while `cmt_line_owned` is 1.
- R4: Only the oldest store commits on lane 0 (`cmt_valid` bit 0), and only in a cycle where `cmt_line_owned` is 1. Stores leave in program order.
- R5: Lane 1 (`cmt_valid` bit 1) carries the second-oldest store in the same cycle as lane 0 only when that store is retired and its line (address bits above bit 5) equals the head's line. Otherwise `cmt_valid` is 2'b01.
- R6: A flush drops all unretired stores. The store data of dropped entries is no longer forwarded, and the next free slot follows the last retired entry. Retired stores still commit after the flush.
- R7: `pf_valid` requests the line (address bits above bit 5) of the oldest executed entry that has not yet had a request accepted. The request is held until `pf_ready` is 1, and then moves on to the next such entry.
- R8: A load whose byte address exactly matches one or more executed buffered stores gets `ld_hit` = 1 and the data of the youngest of them. With no match, `ld_hit` is 0.
- R9: `drained` is 1 exactly when the queue holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Claim a slot for the next store in program order |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | IW | Slot tag given to the claiming store |
| exec_valid | input | 1 | Executed store writes its address and data |
| exec_tag | input | IW | Slot being written |
| exec_addr | input | AW | Byte address |
| exec_data | input | DW | Store byte |
| retire_valid | input | 1 | Retire the oldest unretired store |
| flush | input | 1 | Discard all unretired stores |
| cmt_valid | output | 2 | Commit lanes 0 and 1 fire this cycle |
| cmt_line | output | LW | Line of the head store, shown to the cache |
| cmt_addr0 | output | AW | Lane 0 address |
| cmt_data0 | output | DW | Lane 0 data |
| cmt_addr1 | output | AW | Lane 1 address |
| cmt_data1 | output | DW | Lane 1 data |
| cmt_line_owned | input | 1 | Cache holds `cmt_line` in Exclusive or Modified state |
| pf_valid | output | 1 | Ownership prefetch request |
| pf_line | output | LW | Line to fetch with ownership |
| pf_ready | input | 1 | Prefetch request accepted |
| ld_addr | input | AW | Load byte address to search |
| ld_hit | output | 1 | A buffered store matches |
| ld_data | output | DW | Forwarded byte |
| drained | output | 1 | Queue is empty |

## Verification
The hardest states to reach are those where retired and unretired stores are mixed in the queue while the cache grants ownership. Only then can R3, R6 and the lane-1 pairing of R5 be told apart. The stimulus retires just part of the buffered stores and holds `cmt_line_owned` high over an unretired head. It then flushes with one retired store left behind. A separate pass places two retired stores in one line and two in different lines, so both outcomes of the pairing rule are seen. The full-queue case is reached by filling all slots, offering one more allocation, and then showing that exactly DEPTH commits empty the queue.

// File: rtl/store_commit_queue.sv
module store_commit_queue #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int LINE_BYTES = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int OW = $clog2(LINE_BYTES),
  localparam int LW = AW - OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          exec_valid,
  input  logic [IW-1:0] exec_tag,
  input  logic [AW-1:0] exec_addr,
  input  logic [DW-1:0] exec_data,
  input  logic          retire_valid,
  input  logic          flush,
  output logic [1:0]    cmt_valid,
  output logic [LW-1:0] cmt_line,
  output logic [AW-1:0] cmt_addr0,
  output logic [DW-1:0] cmt_data0,
  output logic [AW-1:0] cmt_addr1,
  output logic [DW-1:0] cmt_data1,
  input  logic          cmt_line_owned,
  output logic          pf_valid,
  output logic [LW-1:0] pf_line,
  input  logic          pf_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          drained
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] head;
  logic [CW-1:0] cnt, rcnt;
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] exe_q, pf_q;

  logic [IW-1:0] tail, h1, ret_slot, pf_idx;
  logic [CW-1:0] ncmt, cnt_nxt, rcnt_nxt;
  logic alloc_fire, ret_ok;

  assign tail        = head + cnt[IW-1:0];
  assign h1          = head + IW'(1);
  assign ret_slot    = head + rcnt[IW-1:0];
  assign alloc_ready = cnt < CW'(DEPTH);
  assign alloc_tag   = tail;
  assign alloc_fire  = alloc_valid && alloc_ready && !flush;
  assign ret_ok      = retire_valid && (rcnt < cnt);
  assign drained     = cnt == '0;

  assign cmt_line  = addr_q[head][AW-1:OW];
  assign cmt_addr0 = addr_q[head];
  assign cmt_data0 = data_q[head];
  assign cmt_addr1 = addr_q[h1];
  assign cmt_data1 = data_q[h1];
  assign cmt_valid[0] = (rcnt != '0) && cmt_line_owned;
  assign cmt_valid[1] = cmt_valid[0] && (rcnt >= CW'(2)) &&
                        (addr_q[h1][AW-1:OW] == cmt_line);
  assign ncmt = CW'(cmt_valid[0]) + CW'(cmt_valid[1]);

  assign rcnt_nxt = rcnt - ncmt + CW'(ret_ok);
  assign cnt_nxt  = flush ? rcnt_nxt : (cnt - ncmt + CW'(alloc_fire));

  always_comb begin
    logic [IW-1:0] s;
    s = '0;
    ld_hit = 1'b0;
    ld_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = head + IW'(k);
      if (CW'(k) < cnt && exe_q[s] && addr_q[s] == ld_addr) begin
        ld_hit = 1'b1;
        ld_data = data_q[s];
      end
    end
  end

  always_comb begin
    logic [IW-1:0] s;
    s = '0;
    pf_valid = 1'b0;
    pf_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = head + IW'(k);
      if (!pf_valid && CW'(k) < cnt && exe_q[s] && !pf_q[s]) begin
        pf_valid = 1'b1;
        pf_idx = s;
      end
    end
  end
  assign pf_line = addr_q[pf_idx][AW-1:OW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      cnt   <= '0;
      rcnt  <= '0;
      exe_q <= '0;
      pf_q  <= '0;
    end else begin
      head <= head + ncmt[IW-1:0];
      cnt  <= cnt_nxt;
      rcnt <= rcnt_nxt;
      if (pf_valid && pf_ready) pf_q[pf_idx] <= 1'b1;
      if (exec_valid) begin
        exe_q[exec_tag]  <= 1'b1;
        addr_q[exec_tag] <= exec_addr;
        data_q[exec_tag] <= exec_data;
      end
      if (alloc_fire) begin
        exe_q[tail] <= 1'b0;
        pf_q[tail]  <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready |=> cnt <= $past(cnt)); // R2
  AST_RETIRE_EXECUTED: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |-> exe_q[ret_slot]); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush && rcnt == '0 && !retire_valid |=> drained); // R6
  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !flush && !exec_valid && cmt_valid == 2'b00
    |=> pf_valid && $stable(pf_line)); // R7
  AST_DRAINED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> cmt_valid == 2'b00 && !pf_valid && !ld_hit); // R9
endmodule

// File: tb/store_commit_queue_tb.sv
module store_commit_queue_tb_top;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, exec_valid = 0, retire_valid = 0, flush = 0;
  logic cmt_line_owned = 0, pf_ready = 0;
  logic [2:0] exec_tag = 0;
  logic [31:0] exec_addr = 0, ld_addr = 0;
  logic [7:0] exec_data = 0;
  logic alloc_ready, pf_valid, ld_hit, drained;
  logic [2:0] alloc_tag;
  logic [1:0] cmt_valid;
  logic [25:0] cmt_line, pf_line;
  logic [31:0] cmt_addr0, cmt_addr1;
  logic [7:0] cmt_data0, cmt_data1, ld_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  store_commit_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_addr(exec_addr), .exec_data(exec_data),
    .retire_valid(retire_valid), .flush(flush),
    .cmt_valid(cmt_valid), .cmt_line(cmt_line),
    .cmt_addr0(cmt_addr0), .cmt_data0(cmt_data0),
    .cmt_addr1(cmt_addr1), .cmt_data1(cmt_data1),
    .cmt_line_owned(cmt_line_owned),
    .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .drained(drained));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic alloc_one(output logic [2:0] t);
    alloc_valid = 1; #1; t = alloc_tag; tick(); alloc_valid = 0;
  endtask

  task automatic exec_one(logic [2:0] t, logic [31:0] a, logic [7:0] d);
    exec_valid = 1; exec_tag = t; exec_addr = a; exec_data = d; tick(); exec_valid = 0;
  endtask

  task automatic retire_one();
    retire_valid = 1; tick(); retire_valid = 0;
  endtask

  task automatic load_chk(string req, logic [31:0] a, logic hit, logic [7:0] d);
    ld_addr = a; #1;
    chk(req, ld_hit, hit);
    if (hit) chk(req, ld_data, d);
  endtask

  task automatic commit_chk(string req, logic [1:0] v, logic [31:0] a0, logic [7:0] d0);
    cmt_line_owned = 1; #1;
    chk(req, cmt_valid, v);
    if (v[0]) begin chk(req, cmt_addr0, a0); chk(req, cmt_data0, d0); end
    tick(); cmt_line_owned = 0;
  endtask

  task automatic t_reset();
    chk("R1 drained", drained, 1);
    chk("R1 ready", alloc_ready, 1);
    chk("R1 tag", alloc_tag, 0);
    chk("R1 cmt", cmt_valid, 0);
    chk("R1 pf", pf_valid, 0);
  endtask

  task automatic t_basic();
    logic [2:0] a, b, c;
    alloc_one(a); alloc_one(b); alloc_one(c);
    chk("R2 tag0", a, 0); chk("R2 tag1", b, 1); chk("R2 tag2", c, 2);
    exec_one(a, 32'h100, 8'h11);
    exec_one(b, 32'h200, 8'h22);
    exec_one(c, 32'h100, 8'h33);
    load_chk("R8 youngest", 32'h100, 1, 8'h33);
    load_chk("R8 single", 32'h200, 1, 8'h22);
    load_chk("R8 miss", 32'h101, 0, 0);
    #1; chk("R7 first", pf_valid, 1); chk("R7 line", pf_line, 26'h4);
    tick(); chk("R7 held", pf_line, 26'h4);
    pf_ready = 1; tick(); chk("R7 next", pf_line, 26'h8);
    tick(); chk("R7 third", pf_line, 26'h4);
    tick(); pf_ready = 0; chk("R7 done", pf_valid, 0);
    cmt_line_owned = 1; #1; chk("R3 unretired", cmt_valid, 0); cmt_line_owned = 0;
    chk("R9 busy", drained, 0);
    retire_one(); retire_one();
    #1; chk("R4 not owned", cmt_valid, 0);
    commit_chk("R5 diff line", 2'b01, 32'h100, 8'h11);
    commit_chk("R4 order", 2'b01, 32'h200, 8'h22);
    commit_chk("R3 head unretired", 2'b00, 0, 0);
    load_chk("R8 still", 32'h100, 1, 8'h33);
    retire_one();
    commit_chk("R4 last", 2'b01, 32'h100, 8'h33);
    #1; chk("R9 empty", drained, 1);
    load_chk("R8 gone", 32'h100, 0, 0);
  endtask

  task automatic t_pair();
    logic [2:0] a, b;
    alloc_one(a); alloc_one(b);
    exec_one(a, 32'h140, 8'hA1);
    exec_one(b, 32'h17F, 8'hA2);
    retire_one(); retire_one();
    cmt_line_owned = 1; #1;
    chk("R5 pair", cmt_valid, 2'b11);
    chk("R5 line", cmt_line, 26'h5);
    chk("R5 addr1", cmt_addr1, 32'h17F);
    chk("R5 data1", cmt_data1, 8'hA2);
    tick(); cmt_line_owned = 0;
    chk("R5 drained", drained, 1);
  endtask

  task automatic t_flush();
    logic [2:0] a, b, c, n;
    alloc_one(a); alloc_one(b); alloc_one(c);
    exec_one(a, 32'h300, 8'h51);
    exec_one(b, 32'h340, 8'h52);
    exec_one(c, 32'h380, 8'h53);
    retire_one();
    flush = 1; tick(); flush = 0;
    load_chk("R6 dropped", 32'h380, 0, 0);
    load_chk("R6 kept", 32'h300, 1, 8'h51);
    #1; n = alloc_tag; chk("R6 tail", n, a + 3'd1);
    commit_chk("R6 commit", 2'b01, 32'h300, 8'h51);
    chk("R6 empty", drained, 1);
  endtask

  task automatic t_full();
    logic [2:0] t [8];
    for (int i = 0; i < 8; i++) alloc_one(t[i]);
    chk("R2 full", alloc_ready, 0);
    alloc_valid = 1; tick(); alloc_valid = 0;
    for (int i = 0; i < 8; i++) exec_one(t[i], 32'h1000 + 32'(i) * 64, 8'(i));
    for (int i = 0; i < 8; i++) retire_one();
    for (int i = 0; i < 8; i++)
      commit_chk("R4 full drain", 2'b01, 32'h1000 + 32'(i) * 64, 8'(i));
    chk("R2 extra ignored", drained, 1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1; #1;
    t_reset();
    t_basic();
    t_pair();
    t_flush();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule